// File: doc/BRIEF.md
# SPI Event Flag and Interrupt Mask Unit

This block holds the event flags of an SPI controller together with an enable mask for each flag. Five hardware event pulses set sticky flags: multimaster collision, transmit error, receive-discarded busy, transmit buffer done and receive buffer done. Software reads the flags, and clears any subset of them by writing ones to the flag register. A zero in the write data leaves that flag unchanged. A second register of the same width enables the flags that may raise the interrupt.

The single interrupt request is high while any flag is set and enabled. It stays high until software clears every enabled flag that is set, or masks it. The multimaster flag reports that the external slave-select input was driven while the controller acts as master. The busy flag reports a received character that was dropped because no receive buffer was free. The logic that detects these conditions sits outside this block.

Registers use vector index 7 as the most significant bit.

Top module: `spi_evt_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the flag register and the mask register are cleared to all zeros, and `irq` and `rd_data` are 0.
- R2: A one-cycle pulse on an event input sets its flag at the next edge, and the flag stays set after the pulse ends. The flag positions are: multimaster `ev_mm_err` at bit 5, transmit error `ev_tx_err` at bit 4, busy `ev_busy` at bit 2, transmit done `ev_tx_done` at bit 1, receive done `ev_rx_done` at bit 0.
- R3: A write with `sel_evt` high clears every flag whose `wdata` bit is 1. Flags whose `wdata` bit is 0 keep their value.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A write with `sel_msk` high loads the mask register from `wdata`, restricted to the implemented bits.
- R6: Bits 7, 6 and 3 are reserved in both registers. They always read as 0, and writes to them have no effect.
- R7: `irq` is registered. It equals the OR over all bits of (flag AND mask) as they stood one edge earlier. A mask bit of 1 enables its flag and a mask bit of 0 blocks it.
- R8: `rd_data` is registered. One edge after the selects are sampled, it shows the flag register when `sel_evt` is high, otherwise the mask register when `sel_msk` is high, and otherwise 0.
- R9: A flag write leaves the mask register unchanged, and a mask write leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected register(s) |
| sel_evt | input | 1 | Selects the flag register |
| sel_msk | input | 1 | Selects the mask register |
| wdata | input | 8 | Write data (ones clear flags; mask value) |
| rd_data | output | 8 | Registered read data |
| ev_mm_err | input | 1 | Multimaster collision pulse |
| ev_tx_err | input | 1 | Transmit error pulse |
| ev_busy | input | 1 | Received character discarded pulse |
| ev_tx_done | input | 1 | Transmit buffer done pulse |
| ev_rx_done | input | 1 | Receive buffer done pulse |
| irq | output | 1 | Interrupt request |

## Verification
An event pulse or write that is sampled at edge k changes the registers at edge k. The interrupt output follows at edge k+1, and a read started at edge k+1 shows the new value at edge k+2. The bench drives every input on the falling edge. It then waits exactly the number of rising edges each result needs and samples on the next falling edge. The timing sweep checks `irq` both one edge after the flag update and the edge before it, so an extra or a missing pipeline stage shows up as a mismatch.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int EVT_W = 8;
  localparam int B_MM  = 5;
  localparam int B_TXE = 4;
  localparam int B_BSY = 2;
  localparam int B_TXD = 1;
  localparam int B_RXD = 0;
  localparam logic [EVT_W-1:0] IMPL_BITS =
    (EVT_W'(1) << B_MM) | (EVT_W'(1) << B_TXE) | (EVT_W'(1) << B_BSY) |
    (EVT_W'(1) << B_TXD) | (EVT_W'(1) << B_RXD);
endpackage

// File: rtl/spi_evt_flags.sv
module spi_evt_flags #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] flags_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= 1'b0;
        else if (set_i[i])
          q <= 1'b1;
        else if (clr_en && clr_bits[i])
          q <= 1'b0;
      end
      assign flags_o[i] = q;
    end else begin : g_rsvd
      assign flags_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/spi_evt_mask.sv
module spi_evt_mask #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] mask_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= 1'b0;
        else if (ld_en)
          q <= ld_data[i];
      end
      assign mask_o[i] = q;
    end else begin : g_rsvd
      assign mask_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/spi_evt_out.sv
module spi_evt_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] mask_i,
  input  logic         sel_evt,
  input  logic         sel_msk,
  output logic         irq_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] rd_nxt;

  always_comb begin
    if (sel_evt)
      rd_nxt = flags_i;
    else if (sel_msk)
      rd_nxt = mask_i;
    else
      rd_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      rd_o  <= '0;
    end else begin
      irq_o <= |(flags_i & mask_i);
      rd_o  <= rd_nxt;
    end
  end
endmodule

// File: rtl/spi_evt_unit.sv
module spi_evt_unit
  import spi_evt_pkg::*;
#(
  parameter int W = EVT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         sel_evt,
  input  logic         sel_msk,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rd_data,
  input  logic         ev_mm_err,
  input  logic         ev_tx_err,
  input  logic         ev_busy,
  input  logic         ev_tx_done,
  input  logic         ev_rx_done,
  output logic         irq
);
  localparam logic [W-1:0] IMPL = W'(IMPL_BITS);

  logic [W-1:0] set_vec;
  logic [W-1:0] evt_q;
  logic [W-1:0] msk_q;

  always_comb begin
    set_vec        = '0;
    set_vec[B_MM]  = ev_mm_err;
    set_vec[B_TXE] = ev_tx_err;
    set_vec[B_BSY] = ev_busy;
    set_vec[B_TXD] = ev_tx_done;
    set_vec[B_RXD] = ev_rx_done;
  end

  spi_evt_flags #(.W(W), .IMPL(IMPL)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_vec),
    .clr_en   (wr_en && sel_evt),
    .clr_bits (wdata),
    .flags_o  (evt_q)
  );

  spi_evt_mask #(.W(W), .IMPL(IMPL)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (wr_en && sel_msk),
    .ld_data (wdata),
    .mask_o  (msk_q)
  );

  spi_evt_out #(.W(W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .flags_i (evt_q),
    .mask_i  (msk_q),
    .sel_evt (sel_evt),
    .sel_msk (sel_msk),
    .irq_o   (irq),
    .rd_o    (rd_data)
  );
endmodule

// File: rtl/spi_evt_unit_chk.sv
module spi_evt_unit_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] RSVD = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         sel_evt,
  input logic         sel_msk,
  input logic [W-1:0] wdata,
  input logic [W-1:0] set_vec,
  input logic [W-1:0] evt,
  input logic [W-1:0] msk,
  input logic         irq,
  input logic [W-1:0] rd_data
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (evt == '0 && msk == '0 && !irq && rd_data == '0));

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel_evt) |=> ((evt & $past(evt)) == $past(evt)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_evt) |=> ((evt & $past(wdata & ~set_vec)) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((evt & $past(set_vec)) == $past(set_vec)));

  p_mask_load_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_msk) |=> (msk == ($past(wdata) & ~RSVD)));

  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ((evt & RSVD) == '0) && ((msk & RSVD) == '0));

  p_irq_follow_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(evt & msk))));

  p_read_evt_r8: assert property (@(posedge clk) disable iff (rst)
    sel_evt |=> (rd_data == $past(evt)));

  p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel_msk) |=> $stable(msk));
endmodule

bind spi_evt_unit spi_evt_unit_chk #(.W(W), .RSVD(~IMPL)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .sel_evt (sel_evt),
  .sel_msk (sel_msk),
  .wdata   (wdata),
  .set_vec (set_vec),
  .evt     (evt_q),
  .msk     (msk_q),
  .irq     (irq),
  .rd_data (rd_data)
);

// File: tb/spi_evt_unit_bench.sv
module spi_evt_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, sel_evt = 1'b0, sel_msk = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic       ev_mm_err = 0, ev_tx_err = 0, ev_busy = 0, ev_tx_done = 0, ev_rx_done = 0;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  spi_evt_unit u_spi_evt_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel_evt(sel_evt), .sel_msk(sel_msk),
    .wdata(wdata), .rd_data(rd_data), .ev_mm_err(ev_mm_err), .ev_tx_err(ev_tx_err),
    .ev_busy(ev_busy), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .irq(irq)
  );

  localparam logic [7:0] VALID = 8'b0011_0111;

  // event vector order: [4]=mm(bit5) [3]=txe(bit4) [2]=busy(bit2) [1]=txd(bit1) [0]=rxd(bit0)
  function automatic logic [7:0] ev_map(input logic [4:0] e);
    return {2'b00, e[4], e[3], 1'b0, e[2], e[1], e[0]};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] e);
    {ev_mm_err, ev_tx_err, ev_busy, ev_tx_done, ev_rx_done} = e;
    tick();
    {ev_mm_err, ev_tx_err, ev_busy, ev_tx_done, ev_rx_done} = '0;
  endtask

  task automatic wr_evt(input logic [7:0] d);
    wr_en = 1; sel_evt = 1; wdata = d;
    tick();
    wr_en = 0; sel_evt = 0; wdata = '0;
  endtask

  task automatic wr_msk(input logic [7:0] d);
    wr_en = 1; sel_msk = 1; wdata = d;
    tick();
    wr_en = 0; sel_msk = 0; wdata = '0;
  endtask

  task automatic rd(input bit evt_sel, output logic [7:0] v);
    sel_evt = evt_sel; sel_msk = !evt_sel;
    tick();
    sel_evt = 0; sel_msk = 0;
    v = rd_data;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    tick(); tick();
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
    rst = 0;
    rd(1, v); chk("R1 flags", v, 8'h00);
    rd(0, v); chk("R1 mask", v, 8'h00);

    // R5 R6 R9: all mask values
    for (int m = 0; m < 256; m++) begin
      wr_msk(8'(m));
      rd(0, v); chk("R5/R6 mask readback", v, 8'(m) & VALID);
    end
    rd(1, v); chk("R9 flags untouched by mask writes", v, 8'h00);

    // R2 R3 R7 sweep over events x masks
    for (int m = 0; m < 32; m++) begin
      for (int e = 0; e < 32; e++) begin
        logic [7:0] em, mm;
        em = ev_map(5'(e)); mm = ev_map(5'(m));
        wr_evt(8'hFF);
        wr_msk(mm);
        pulse(5'(e));
        chk("R7 irq not early", {7'b0, irq}, 8'h00);
        tick();
        chk("R7 irq", {7'b0, irq}, {7'b0, |(em & mm)});
        rd(1, v); chk("R2 sticky flags", v, em);
      end
    end

    // R3 partial clear and R9 mask held
    wr_msk(8'hFF);
    wr_evt(8'hFF);
    pulse(5'b11111);
    wr_evt(8'b0010_0100);
    rd(1, v); chk("R3 partial clear", v, 8'b0001_0011);
    rd(0, v); chk("R9 mask held across flag write", v, VALID);
    wr_evt(8'h00);
    rd(1, v); chk("R3 zero write keeps flags", v, 8'b0001_0011);
    chk("R7 irq held while enabled flag set", {7'b0, irq}, 8'h01);
    wr_msk(8'h00);
    tick();
    chk("R7 irq dropped by mask", {7'b0, irq}, 8'h00);
    wr_evt(8'hFF);

    // R4 set wins over clear
    ev_busy = 1; wr_en = 1; sel_evt = 1; wdata = 8'hFF;
    tick();
    ev_busy = 0; wr_en = 0; sel_evt = 0; wdata = '0;
    rd(1, v); chk("R4 set wins", v, 8'b0000_0100);

    // R8 no select reads zero
    sel_evt = 0; sel_msk = 0;
    tick();
    chk("R8 no select", rd_data, 8'h00);
    sel_evt = 1; sel_msk = 1;
    tick();
    sel_evt = 0; sel_msk = 0;
    chk("R8 flag priority", rd_data, 8'b0000_0100);

    // R1 reset again
    rst = 1; tick(); rst = 0;
    rd(1, v); chk("R1 flags after reset", v, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule